// File: doc/BRIEF.md
# Parallel Eight-Tap FIR Multiply-Accumulate Engine

This block sits next to a processor's general datapath and computes a finite impulse response filter with fixed coefficients. While a filter run is active it takes one signed sample on every clock and shifts it into a window of eight stored samples. Eight multipliers work on the whole window at once, and an adder tree sums their products. The result is one full-precision filter output per clock, and the general-purpose ALU is never used for the filtering.

A run starts when `run_i` is seen high and continues on its own until a user stop input is seen high. For the whole run the block asks the processor to hold instruction fetch. Samples are stored in offset-binary form, and the adder tree removes that offset, so the output is the exact signed convolution. No result is marked valid until the window holds eight samples from the current run. Each result is presented first on the accumulator-side output and is then offered to the register file one clock later. A stop cancels both stages at once and ends the hold on fetch.

Top module: `pfir_engine`

## Requirements
- R1: While `rst_n` is low, `hold_fetch_o`, `acc_vld_o` and `rf_wr_o` are low, and `acc_o` and `rf_data_o` are zero.
- R2: A clock edge with `run_i` high and `stop_i` low starts a run. `hold_fetch_o` is high after that edge and stays high until a stop. `run_i` has no effect while a run is active.
- R3: At every edge inside a run where `stop_i` is low, the value on `smp_i` (signed two's complement) becomes the newest sample of the window.
- R4: A result equals the sum over k = 0..TAPS-1 of `COEFS[k*CW +: CW]` (signed) times the sample taken k edges before the newest sample of its window. It is exact, signed, and DW+CW+log2(TAPS) bits wide.
- R5: No result is valid until TAPS samples of the current run have been taken. The first valid result, for the window ending at the TAPS-th sample, appears on `acc_o` at the edge that takes the next sample.
- R6: Once the first result is out, `acc_vld_o` stays high with a new result at every edge until a stop. There are no gaps and no missing windows.
- R7: At every edge where `acc_vld_o` was high and `stop_i` is low, `rf_wr_o` goes high and `rf_data_o` takes the value `acc_o` had before that edge. Otherwise `rf_wr_o` is low.
- R8: An edge with `stop_i` high ends the run. After that edge `hold_fetch_o`, `acc_vld_o` and `rf_wr_o` are low, and the sample at that edge is not taken. A stop wins over `run_i` at the same edge.
- R9: After a stop, a new run again needs TAPS fresh samples before its first result. No sample from an earlier run ever contributes.
- R10: Full-scale samples (-2^(DW-1) and 2^(DW-1)-1) give exact results. The offset added for storage is fully removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Start a filter run |
| stop_i | input | 1 | User stop; ends the run |
| smp_i | input | DW | Signed input sample |
| hold_fetch_o | output | 1 | Request to hold instruction fetch during a run |
| acc_vld_o | output | 1 | `acc_o` holds a new result |
| acc_o | output | DW+CW+log2(TAPS) | Filter result on the accumulator side |
| rf_wr_o | output | 1 | Register-file write strobe |
| rf_data_o | output | DW+CW+log2(TAPS) | Result offered to the register file |

## Verification
The bench checks every result against an independent convolution model with asymmetric, mixed-sign coefficients. A design with reversed tap order, a wrong offset correction or a one-cycle slip in the window would give wrong values. It also counts cycles to the first valid result, so a fill counter that is off by one would show up as a result that is early or missing. Short runs followed by restarts test whether stale samples leak into a new run or whether a stop fails to clear the fill count. Full-scale alternating and constant negative samples test the offset removal and the accumulator width. A stop asserted together with `run_i` at idle, and a stop that lands while both pipeline stages are busy, test that no late write or hold request survives the stop.

// File: rtl/pfir_pkg.sv
package pfir_pkg;

   // True when n is a power of two of at least two (adder tree needs it).
   function automatic bit is_pow2(int unsigned n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

   // Depth of the binary reduction for n leaves.
   function automatic int unsigned tree_depth(int unsigned n);
      return $clog2(n);
   endfunction

endpackage

// File: rtl/pfir_window.sv
module pfir_window #(
   parameter int DW   = 16,
   parameter int TAPS = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     shift_en,
   input  logic                     flush,
   input  logic signed [DW-1:0]     smp_i,
   output logic [TAPS-1:0][DW-1:0]  taps_o,
   output logic                     full_o
);
   localparam int             FW       = $clog2(TAPS + 1);
   localparam logic [FW-1:0]  FULL_CNT = FW'(TAPS);

   logic [TAPS-1:0][DW-1:0] line_q;
   logic [FW-1:0]           fill_q;
   logic [DW-1:0]           biased;

   // Offset binary: adding 2^(DW-1) equals flipping the sign bit.
   assign biased = {~smp_i[DW-1], smp_i[DW-2:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         line_q <= '0;
      else if (shift_en)
         line_q <= {line_q[TAPS-2:0], biased};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         fill_q <= '0;
      else if (flush)
         fill_q <= '0;
      else if (shift_en && (fill_q != FULL_CNT))
         fill_q <= fill_q + 1'b1;
   end

   assign taps_o = line_q;
   assign full_o = (fill_q == FULL_CNT);

   // R9
   flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (fill_q == '0) && !full_o);

   // R6
   full_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && !flush) |=> full_o);

   // R5
   fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && !shift_en) |=> $stable(fill_q));

endmodule

// File: rtl/pfir_products.sv
module pfir_products #(
   parameter int                  DW    = 16,
   parameter int                  CW    = 16,
   parameter int                  TAPS  = 8,
   parameter int                  AW    = DW + CW + 3,
   parameter logic [TAPS*CW-1:0]  COEFS = '0
) (
   input  logic [TAPS-1:0][DW-1:0]  taps_i,
   output logic [TAPS-1:0][AW-1:0]  prod_o
);
   generate
      for (genvar k = 0; k < TAPS; k++) begin : g_mul
         localparam logic signed [CW-1:0] CK = COEFS[k*CW +: CW];
         if (CK == '0) begin : g_zero
            // A zero tap needs no multiplier.
            assign prod_o[k] = '0;
         end else begin : g_mult
            logic signed [AW-1:0] smp_ext;
            logic signed [AW-1:0] coef_ext;
            assign smp_ext  = AW'(taps_i[k]);
            assign coef_ext = AW'(CK);
            assign prod_o[k] = smp_ext * coef_ext;
         end
      end
   endgenerate

endmodule

// File: rtl/pfir_sum_tree.sv
module pfir_sum_tree #(
   parameter int                 TAPS      = 8,
   parameter int                 AW        = 35,
   parameter logic signed [AW-1:0] BIAS_CORR = '0
) (
   input  logic [TAPS-1:0][AW-1:0] prod_i,
   output logic signed [AW-1:0]    sum_o
);
   localparam int NODES = 2 * TAPS - 1;

   // Heap layout: node n sums children 2n+1 and 2n+2; leaves at TAPS-1 upward.
   logic [AW-1:0] node [NODES];

   generate
      for (genvar l = 0; l < TAPS; l++) begin : g_leaf
         assign node[TAPS-1+l] = prod_i[l];
      end
      for (genvar n = 0; n < TAPS - 1; n++) begin : g_add
         assign node[n] = node[2*n+1] + node[2*n+2];
      end
   endgenerate

   // Remove the storage offset carried by every product.
   assign sum_o = $signed(node[0]) - BIAS_CORR;

endmodule

// File: rtl/pfir_engine.sv
module pfir_engine #(
   parameter int                 DW    = 16,
   parameter int                 CW    = 16,
   parameter int                 TAPS  = 8,
   parameter logic [TAPS*CW-1:0] COEFS = {16'h0001, 16'h0002, 16'h0004, 16'h0008,
                                          16'h0008, 16'h0004, 16'h0002, 16'h0001},
   localparam int                AW    = DW + CW + $clog2(TAPS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run_i,
   input  logic                 stop_i,
   input  logic signed [DW-1:0] smp_i,
   output logic                 hold_fetch_o,
   output logic                 acc_vld_o,
   output logic signed [AW-1:0] acc_o,
   output logic                 rf_wr_o,
   output logic signed [AW-1:0] rf_data_o
);
   import pfir_pkg::*;

   generate
      if (!is_pow2(TAPS)) begin : g_bad_taps
         $error("pfir_engine: TAPS must be a power of two, at least 2");
      end
      if (DW < 2 || CW < 2) begin : g_bad_width
         $error("pfir_engine: DW and CW must be at least 2");
      end
      if (tree_depth(TAPS) != AW - DW - CW) begin : g_bad_aw
         $error("pfir_engine: accumulator width inconsistent");
      end
   endgenerate

   // Sum of coefficients times 2^(DW-1): offset carried by the biased samples.
   function automatic logic signed [AW-1:0] bias_corr();
      logic signed [AW-1:0] acc;
      logic signed [CW-1:0] c;
      acc = '0;
      for (int k = 0; k < TAPS; k++) begin
         c   = COEFS[k*CW +: CW];
         acc = acc + (AW'(c) <<< (DW - 1));
      end
      return acc;
   endfunction

   localparam logic signed [AW-1:0] CORR = bias_corr();

   logic                    active_q;
   logic                    go;
   logic                    win_full;
   logic                    fire;
   logic [TAPS-1:0][DW-1:0] taps;
   logic [TAPS-1:0][AW-1:0] prods;
   logic signed [AW-1:0]    tree_sum;
   logic                    acc_vld_q;
   logic signed [AW-1:0]    acc_q;
   logic                    rf_wr_q;
   logic signed [AW-1:0]    rf_q;

   // Stop wins over run; run only matters while idle.
   assign go   = (active_q | run_i) & ~stop_i;
   assign fire = active_q & win_full & ~stop_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_q <= 1'b0;
      else        active_q <= go;
   end

   pfir_window #(.DW(DW), .TAPS(TAPS)) u_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (go),
      .flush    (stop_i),
      .smp_i    (smp_i),
      .taps_o   (taps),
      .full_o   (win_full)
   );

   pfir_products #(.DW(DW), .CW(CW), .TAPS(TAPS), .AW(AW), .COEFS(COEFS)) u_products (
      .taps_i (taps),
      .prod_o (prods)
   );

   pfir_sum_tree #(.TAPS(TAPS), .AW(AW), .BIAS_CORR(CORR)) u_tree (
      .prod_i (prods),
      .sum_o  (tree_sum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_vld_q <= 1'b0;
         acc_q     <= '0;
      end else begin
         acc_vld_q <= fire;
         if (fire) acc_q <= tree_sum;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rf_wr_q <= 1'b0;
         rf_q    <= '0;
      end else begin
         rf_wr_q <= acc_vld_q & ~stop_i;
         if (acc_vld_q && !stop_i) rf_q <= acc_q;
      end
   end

   assign hold_fetch_o = active_q;
   assign acc_vld_o    = acc_vld_q;
   assign acc_o        = acc_q;
   assign rf_wr_o      = rf_wr_q;
   assign rf_data_o    = rf_q;

   // R2
   run_holds_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !stop_i) |=> hold_fetch_o);

   // R8
   stop_quiets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> !hold_fetch_o && !acc_vld_o && !rf_wr_o);

   // R5
   valid_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_vld_o |-> $past(win_full));

   // R6
   steady_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vld_o && !stop_i) |=> acc_vld_o);

   // R7
   rf_follows_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_wr_o |-> $past(acc_vld_o) && (rf_data_o == $past(acc_o)));

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> !hold_fetch_o && !acc_vld_o && !rf_wr_o);

endmodule

// File: tb/test_pfir_engine.sv
module test_pfir_engine;
   localparam int DW   = 16;
   localparam int CW   = 16;
   localparam int TAPS = 8;
   localparam int AW   = DW + CW + 3;
   localparam int CF [8] = '{3, -5, 7, 11, 13, -17, 19, -23};

   function automatic logic [TAPS*CW-1:0] pack_cf();
      logic [TAPS*CW-1:0] v;
      v = '0;
      for (int k = 0; k < TAPS; k++) v[k*CW +: CW] = CW'(CF[k]);
      return v;
   endfunction
   localparam logic [TAPS*CW-1:0] CPK = pack_cf();

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 run = 1'b0;
   logic                 stop = 1'b0;
   logic signed [DW-1:0] smp = '0;
   logic                 hold_fetch;
   logic                 acc_vld;
   logic signed [AW-1:0] acc;
   logic                 rf_wr;
   logic signed [AW-1:0] rf_data;

   int     checks = 0;
   int     errors = 0;
   bit     mon_on = 1'b0;
   string  phase  = "R1 reset";
   longint exp_q [$];
   int     hist [$];

   always #5 clk = ~clk;

   pfir_engine #(.DW(DW), .CW(CW), .TAPS(TAPS), .COEFS(CPK)) i_pfir_engine (
      .clk          (clk),
      .rst_n        (rst_n),
      .run_i        (run),
      .stop_i       (stop),
      .smp_i        (smp),
      .hold_fetch_o (hold_fetch),
      .acc_vld_o    (acc_vld),
      .acc_o        (acc),
      .rf_wr_o      (rf_wr),
      .rf_data_o    (rf_data)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s [%s] actual=%0d expected=%0d", tag, phase, act, exp);
      end
   endtask

   function automatic int gen(input int kind, input int i);
      case (kind)
         0: return i * 37 - 300;
         1: return int'($signed(16'($urandom)));
         2: return (i % 2 == 1) ? 32767 : -32768;
         3: return -32768;
         default: return 20000 + i * 111;
      endcase
   endfunction

   // Driver: one sample per edge; pushes the expected result for the window
   // that the coming edge completes on the accumulator side (R5, R6).
   task automatic burst(input int n, input int kind);
      for (int i = 0; i < n; i++) begin
         int     s;
         longint y;
         @(negedge clk);
         s = gen(kind, i);
         if (hist.size() >= TAPS) begin
            y = 0;
            for (int k = 0; k < TAPS; k++) y += longint'(CF[k]) * longint'(hist[k]);
            exp_q.push_back(y);
         end
         hist.push_front(s);
         smp  = DW'(s);
         run  = (i == 0) ? 1'b1 : (i % 3 == 1);
         stop = 1'b0;
      end
      @(negedge clk);
      stop = 1'b1;
      run  = (kind == 1);
      smp  = DW'(12345);
      @(negedge clk);
      stop = 1'b0;
      run  = 1'b0;
      hist.delete();
   endtask

   // Monitor: checks outputs just after each edge.
   bit     m_act = 1'b0;
   bit     p_vld = 1'b0;
   longint p_acc = 0;
   always @(posedge clk) begin
      #2;
      if (mon_on) begin
         longint e;
         bit     exp_wr;
         // R2, R8: fetch hold follows run/stop
         m_act = (m_act || run) && !stop;
         chk(hold_fetch === m_act, "R2/R8 hold_fetch", longint'(hold_fetch), longint'(m_act));
         if (acc_vld) begin
            if (exp_q.size() == 0)
               chk(1'b0, "R5 unexpected result", longint'(acc), 0);
            else begin
               e = exp_q.pop_front();
               // R3, R4: exact convolution of the taken samples
               chk(longint'(acc) == e, "R3/R4 filter value", longint'(acc), e);
            end
         end else if (exp_q.size() != 0) begin
            e = exp_q.pop_front();
            chk(1'b0, "R6 missing result", 0, e);
         end
         // R7: register-file stage one edge behind; R8: cancelled by stop
         exp_wr = p_vld && !stop;
         chk(rf_wr === exp_wr, "R7 rf_wr", longint'(rf_wr), longint'(exp_wr));
         if (exp_wr && rf_wr)
            chk(longint'(rf_data) == p_acc, "R7 rf_data", longint'(rf_data), p_acc);
         p_vld = acc_vld;
         p_acc = longint'(acc);
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(hold_fetch === 1'b0, "R1 hold_fetch", longint'(hold_fetch), 0);
      chk(acc_vld === 1'b0, "R1 acc_vld", longint'(acc_vld), 0);
      chk(rf_wr === 1'b0, "R1 rf_wr", longint'(rf_wr), 0);
      chk(acc === '0, "R1 acc", longint'(acc), 0);
      chk(rf_data === '0, "R1 rf_data", longint'(rf_data), 0);
      rst_n  = 1'b1;
      mon_on = 1'b1;
      repeat (3) @(negedge clk);

      // R8: stop with run at idle -> nothing starts
      phase = "R8 stop beats run";
      run = 1'b1; stop = 1'b1; smp = 16'sd999;
      @(negedge clk);
      run = 1'b0; stop = 1'b0;
      repeat (2) @(negedge clk);

      phase = "R4 ramp";
      burst(20, 0);
      repeat (3) @(negedge clk);

      phase = "R4 random";
      burst(30, 1);
      repeat (2) @(negedge clk);

      // R5/R9: short run yields nothing; restart must not see its samples
      phase = "R5 short run";
      burst(5, 4);
      phase = "R9 restart";
      burst(12, 0);
      phase = "R9 exact fill";
      burst(8, 4);
      burst(9, 1);

      phase = "R10 extremes";
      burst(16, 2);
      burst(12, 3);

      repeat (4) @(negedge clk);
      phase = "end";
      chk(exp_q.size() == 0, "R6 leftover expected results", longint'(exp_q.size()), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog [%s] actual=timeout expected=done", phase);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule